// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times the pulse train coming back from a cooling fan's tachometer output. The input pin is brought into the clock domain through a synchronizer and then cleaned by a debounce filter whose depth can be set. The block counts prescaled clock ticks between chosen edges of the cleaned signal. Each completed interval is latched into a count register. A one-cycle update strobe marks the latch, and a sticky full-measurement flag records that at least one whole interval has been seen since the channel was enabled. Software converts the count to a rotation speed. In the mode that times every edge, software doubles the count first.

The latched count is also compared with a programmable limit. In normal mode the interrupt flag sets when the count is above the limit, which means the fan is too slow. In inverted mode it sets when the count is below the limit, which means the fan is too fast. A flag that has been set is cleared by a one-cycle clear strobe. If no edge arrives, the period counter stops at its maximum value and reports that value, so a stalled or missing fan shows up as a full-scale reading.

Top module: `fan_period_meter`

## Requirements
- R1: `rawLevel` equals the value `tachIn` had two clock edges earlier. It passes through a two-flop synchronizer.
- R2: `debounceCode` sets the filter depth. A value of 0 needs 3 consecutive differing synchronized samples before `filtLevel` changes, 1 needs 2, 2 needs 1, and 3 bypasses the filter so `filtLevel` follows `rawLevel` directly.
- R3: `edgeMode` selects the timed edges of `filtLevel`. A value of 1 times rising edge to rising edge. A value of 2 times every edge. A value of 0, and also 3, times falling edge to falling edge.
- R4: With `edgeMode`=2, each count covers a single high or low phase, so two successive counts add up to one full period.
- R5: The count equals floor(P / 4^n), where P is the interval in clock cycles and n is `prescaleExp`. Values of n above 11 behave as 11.
- R6: Each new count appears on `periodCount` together with a one-cycle pulse on `valueUpdated`. `periodCount` holds its value between pulses.
- R7: After `enable` rises, the first edge only starts timing, so the first count reported covers a complete interval. `fullMeasured` sets with that first report. It clears one cycle after `enable` is low, and it stays clear while `enable` is low.
- R8: If no timed edge arrives, the counter stops at 2^COUNT_W-1. That value is reported with `valueUpdated` and `fullMeasured` set.
- R9: On a report, `intFlag` sets when `intEnable`=1, `limitValue`≠0, and the count is greater than the limit (`limitInvert`=0) or less than the limit (`limitInvert`=1). Otherwise the report leaves `intFlag` unchanged.
- R10: A one-cycle pulse on `intClearWr` clears `intFlag` on the next edge, unless a report sets the flag in the same cycle.
- R11: After reset, `periodCount` is 0 and `intFlag`, `valueUpdated` and `fullMeasured` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel run control; a low period restarts measurement |
| intEnable | input | 1 | Allows the limit compare to set the interrupt flag |
| limitInvert | input | 1 | 0: flag when count > limit; 1: flag when count < limit |
| debounceCode | input | 2 | Filter depth code (see R2) |
| edgeMode | input | 2 | Timed-edge selection (see R3) |
| prescaleExp | input | EXP_W | Prescale exponent n, divisor 4^n |
| limitValue | input | COUNT_W | Compare limit; 0 disables the compare |
| intClearWr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| tachIn | input | 1 | Asynchronous tachometer pulse input |
| intFlag | output | 1 | Interrupt flag |
| rawLevel | output | 1 | Synchronized input level |
| filtLevel | output | 1 | Debounced input level |
| valueUpdated | output | 1 | One-cycle pulse when a new count is latched |
| fullMeasured | output | 1 | A complete interval has been measured since enable |
| periodCount | output | COUNT_W | Latched interval count |

## Verification
Steady square and asymmetric pulse trains are used with each edge mode. The input level at the moment of the update tells rising-edge timing apart from falling-edge timing. The split of an asymmetric wave into its high and low phases shows that both-edge mode counts half periods. Pulses one, two and three cycles wide are applied under each debounce code to find where the filter starts to let a pulse through. Periods that are not multiples of the divisor show the truncation of the prescaler. A frozen input drives the counter into saturation. An enable toggled in the middle of a period shows that the first count after restart is a full, fresh one. Interrupt scenarios step the limit above and below the measured count, in both compare directions, and also with the limit at zero.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } meterState_t;

  // edge-mode encodings seen on the edgeMode port
  localparam logic [1:0] EDGE_FALL = 2'd0;
  localparam logic [1:0] EDGE_RISE = 2'd1;
  localparam logic [1:0] EDGE_BOTH = 2'd2;

  // debounce code that bypasses the filter
  localparam logic [1:0] DEB_BYPASS = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // clear period counter and prescaler
    logic capture;  // latch the next count value and run the limit compare
  } meterStrobe_t;

  // number of consecutive differing samples a debounce code asks for
  function automatic logic [1:0] debounceDepth(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd3;
      2'd1:    return 2'd2;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/fpm_input_filter.sv
module fpm_input_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tachIn,
  input  logic [1:0] debounceCode,
  output logic       rawLevel,
  output logic       filtLevel
);
  import fpm_pkg::*;

  logic [SYNC_STAGES-1:0] syncChain;

  // synchronizer chain, one flop per stage
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= tachIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  assign rawLevel = syncChain[SYNC_STAGES-1];

  logic       heldLevel;
  logic [1:0] runLen;
  logic [1:0] depth;
  logic       bypass;

  assign depth  = debounceDepth(debounceCode);
  assign bypass = (debounceCode == DEB_BYPASS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldLevel <= 1'b0;
      runLen    <= '0;
    end else if (bypass) begin
      heldLevel <= rawLevel;
      runLen    <= '0;
    end else if (rawLevel == heldLevel) begin
      runLen <= '0;
    end else if (runLen == depth - 2'd1) begin
      heldLevel <= rawLevel;
      runLen    <= '0;
    end else begin
      runLen <= runLen + 2'd1;
    end
  end

  assign filtLevel = bypass ? rawLevel : heldLevel;

endmodule

// File: rtl/fpm_control.sv
module fpm_control (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [1:0]           edgeMode,
  input  logic                 filtLevel,
  input  logic                 satHit,
  output fpm_pkg::meterStrobe_t strobe,
  output logic                 valueUpdated,
  output logic                 fullMeasured
);
  import fpm_pkg::*;

  meterState_t state, nextState;
  logic        prevLevel;
  logic        riseEv, fallEv, timedEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= filtLevel;
  end

  assign riseEv = filtLevel & ~prevLevel;
  assign fallEv = ~filtLevel & prevLevel;

  always_comb begin
    case (edgeMode)
      EDGE_RISE: timedEv = riseEv;
      EDGE_BOTH: timedEv = riseEv | fallEv;
      default:   timedEv = fallEv;
    endcase
  end

  always_comb begin
    nextState      = state;
    strobe         = '0;
    case (state)
      ST_IDLE: begin
        strobe.restart = 1'b1;
        if (enable) nextState = ST_ARM;
      end
      ST_ARM: begin
        if (!enable) begin
          nextState = ST_IDLE;
        end else if (timedEv) begin
          strobe.restart = 1'b1;
          nextState      = ST_RUN;
        end else if (satHit) begin
          strobe.capture = 1'b1;
          nextState      = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!enable) begin
          nextState = ST_IDLE;
        end else if (timedEv) begin
          strobe.capture = 1'b1;
          strobe.restart = 1'b1;
        end else if (satHit) begin
          strobe.capture = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      valueUpdated <= 1'b0;
      fullMeasured <= 1'b0;
    end else begin
      state        <= nextState;
      valueUpdated <= strobe.capture;
      if (nextState == ST_IDLE)  fullMeasured <= 1'b0;
      else if (strobe.capture)   fullMeasured <= 1'b1;
    end
  end

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath #(
  parameter int COUNT_W = 20,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fpm_pkg::meterStrobe_t strobe,
  input  logic [EXP_W-1:0]      prescaleExp,
  input  logic                  intEnable,
  input  logic                  limitInvert,
  input  logic [COUNT_W-1:0]    limitValue,
  input  logic                  intClearWr,
  output logic                  satHit,
  output logic [COUNT_W-1:0]    periodCount,
  output logic                  intFlag
);
  localparam int PRE_W = 2 * MAX_EXP;
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;
  localparam logic [EXP_W-1:0]   EXP_CAP = EXP_W'(MAX_EXP);

  logic [EXP_W-1:0]   expUse;
  logic [PRE_W:0]     divSpan;
  logic [PRE_W-1:0]   preCnt;
  logic               tick;
  logic [COUNT_W-1:0] runCnt, countNext;
  logic               beyondLimit, setFlag;

  assign expUse  = (prescaleExp > EXP_CAP) ? EXP_CAP : prescaleExp;
  assign divSpan = (PRE_W+1)'(1) << {expUse, 1'b0};
  assign tick    = ({1'b0, preCnt} == divSpan - (PRE_W+1)'(1));

  assign countNext = (tick && runCnt != CNT_MAX) ? runCnt + COUNT_W'(1) : runCnt;
  assign satHit    = tick && (runCnt == CNT_MAX - COUNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      runCnt <= '0;
    end else if (strobe.restart) begin
      preCnt <= '0;
      runCnt <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + PRE_W'(1);
      runCnt <= countNext;
    end
  end

  assign beyondLimit = limitInvert ? (countNext < limitValue) : (countNext > limitValue);
  assign setFlag     = strobe.capture && intEnable && (limitValue != '0) && beyondLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCount <= '0;
      intFlag     <= 1'b0;
    end else begin
      if (strobe.capture) periodCount <= countNext;
      if (setFlag)         intFlag <= 1'b1;
      else if (intClearWr) intFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter #(
  parameter int COUNT_W = 20,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               intEnable,
  input  logic               limitInvert,
  input  logic [1:0]         debounceCode,
  input  logic [1:0]         edgeMode,
  input  logic [EXP_W-1:0]   prescaleExp,
  input  logic [COUNT_W-1:0] limitValue,
  input  logic               intClearWr,
  input  logic               tachIn,
  output logic               intFlag,
  output logic               rawLevel,
  output logic               filtLevel,
  output logic               valueUpdated,
  output logic               fullMeasured,
  output logic [COUNT_W-1:0] periodCount
);
  fpm_pkg::meterStrobe_t strobe;
  logic satHit;

  fpm_input_filter #(.SYNC_STAGES(2)) u_filter (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .debounceCode(debounceCode),
    .rawLevel(rawLevel), .filtLevel(filtLevel)
  );

  fpm_control u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .edgeMode(edgeMode),
    .filtLevel(filtLevel), .satHit(satHit), .strobe(strobe),
    .valueUpdated(valueUpdated), .fullMeasured(fullMeasured)
  );

  fpm_datapath #(.COUNT_W(COUNT_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prescaleExp(prescaleExp),
    .intEnable(intEnable), .limitInvert(limitInvert), .limitValue(limitValue),
    .intClearWr(intClearWr), .satHit(satHit), .periodCount(periodCount),
    .intFlag(intFlag)
  );

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int COUNT_W = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               intEnable,
  input logic [COUNT_W-1:0] limitValue,
  input logic               intClearWr,
  input logic               intFlag,
  input logic               valueUpdated,
  input logic               fullMeasured,
  input logic [COUNT_W-1:0] periodCount
);

  // R7: a low enable clears the full-measurement flag on the next edge
  p_full_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !fullMeasured);

  // R7: every report comes with the full-measurement flag
  p_update_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    valueUpdated |-> fullMeasured);

  // R6: the count only moves together with the update strobe
  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (periodCount != $past(periodCount)) |-> valueUpdated);

  // R9: the flag can only rise on a report with the compare allowed
  p_flag_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> (valueUpdated && $past(intEnable) && ($past(limitValue) != '0)));

  // R10: a clear strobe without a report leaves the flag low
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(intClearWr) && !valueUpdated) |-> !intFlag);

  // R7: reports need the channel to have been enabled
  p_update_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    valueUpdated |-> $past(enable));

endmodule

bind fan_period_meter fpm_checker #(.COUNT_W(COUNT_W)) u_fpm_checker (.*);

// File: tb/tb_fan_period_meter.sv
`timescale 1ns/1ps
module tb_fan_period_meter;
  localparam int CW = 10;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, intEnable = 1'b0, limitInvert = 1'b0, intClearWr = 1'b0;
  logic [1:0] debounceCode = 2'd3, edgeMode = 2'd1;
  logic [3:0] prescaleExp = 4'd0;
  logic [CW-1:0] limitValue = '0;
  logic tachIn = 1'b0;
  logic intFlag, rawLevel, filtLevel, valueUpdated, fullMeasured;
  logic [CW-1:0] periodCount;

  int errors = 0;
  int checks = 0;
  bit genOn = 1'b0;
  int genHigh = 20, genLow = 40;
  int phaseLeft = 1;

  always #2.5 clk = ~clk;

  fan_period_meter #(.COUNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .intEnable(intEnable),
    .limitInvert(limitInvert), .debounceCode(debounceCode), .edgeMode(edgeMode),
    .prescaleExp(prescaleExp), .limitValue(limitValue), .intClearWr(intClearWr),
    .tachIn(tachIn), .intFlag(intFlag), .rawLevel(rawLevel), .filtLevel(filtLevel),
    .valueUpdated(valueUpdated), .fullMeasured(fullMeasured), .periodCount(periodCount)
  );

  // pulse generator: high for genHigh cycles, low for genLow cycles
  initial begin
    forever begin
      @(negedge clk);
      if (genOn) begin
        if (phaseLeft <= 1) begin
          tachIn = ~tachIn;
          phaseLeft = tachIn ? genHigh : genLow;
        end else begin
          phaseLeft--;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic waitUpdate(output int value);
    value = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (valueUpdated) begin
        value = int'(periodCount);
        return;
      end
    end
  endtask

  task automatic restartChannel();
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic testReset();
    check(periodCount == '0, "R11 count", int'(periodCount), 0);
    check(!intFlag && !valueUpdated && !fullMeasured, "R11 flags",
          {intFlag, valueUpdated, fullMeasured}, 0);
  endtask

  task automatic testRaw();
    @(negedge clk); tachIn = 1'b1;
    @(negedge clk);
    check(rawLevel == 1'b0, "R1 after one edge", rawLevel, 0);
    @(negedge clk);
    check(rawLevel == 1'b1, "R1 after two edges", rawLevel, 1);
    tachIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseSeen(input logic [1:0] code, input int width, output bit seen);
    debounceCode = code;
    tachIn = 1'b0;
    repeat (8) @(negedge clk);
    seen = 1'b0;
    tachIn = 1'b1;
    for (int i = 0; i < width; i++) begin
      @(negedge clk); seen |= filtLevel;
    end
    tachIn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); seen |= filtLevel;
    end
  endtask

  task automatic testDebounce();
    bit s;
    pulseSeen(2'd0, 2, s); check(!s, "R2 code0 width2 blocked", s, 0);
    pulseSeen(2'd0, 3, s); check(s,  "R2 code0 width3 passes", s, 1);
    pulseSeen(2'd1, 1, s); check(!s, "R2 code1 width1 blocked", s, 0);
    pulseSeen(2'd1, 2, s); check(s,  "R2 code1 width2 passes", s, 1);
    pulseSeen(2'd2, 1, s); check(s,  "R2 code2 width1 passes", s, 1);
    pulseSeen(2'd3, 1, s); check(s,  "R2 code3 width1 passes", s, 1);
    debounceCode = 2'd3;
  endtask

  task automatic testEdges();
    int v;
    genHigh = 20; genLow = 40; genOn = 1'b1;
    edgeMode = 2'd1; restartChannel();
    waitUpdate(v);
    check(v == 60, "R3 rising count", v, 60);
    check(tachIn == 1'b1, "R3 rising edge timed", tachIn, 1);
    edgeMode = 2'd0; restartChannel();
    waitUpdate(v);
    check(v == 60, "R3 falling count", v, 60);
    check(tachIn == 1'b0, "R3 falling edge timed", tachIn, 0);
    edgeMode = 2'd3; restartChannel();
    waitUpdate(v);
    check(tachIn == 1'b0 && v == 60, "R3 mode3 acts as falling", v, 60);
    @(negedge clk);
    check(!valueUpdated, "R6 update is one cycle", valueUpdated, 0);
    check(periodCount == CW'(60), "R6 count held", int'(periodCount), 60);
  endtask

  task automatic testBoth();
    int a, b;
    edgeMode = 2'd2; restartChannel();
    waitUpdate(a); waitUpdate(b);
    check(a + b == 60 && (a == 20 || a == 40), "R4 half periods", a, 20);
  endtask

  task automatic testPrescale();
    int v;
    edgeMode = 2'd1; genHigh = 40; genLow = 40; prescaleExp = 4'd1;
    restartChannel(); waitUpdate(v);
    check(v == 20, "R5 divide by 4", v, 20);
    genHigh = 84; genLow = 84; prescaleExp = 4'd2;
    restartChannel(); waitUpdate(v);
    check(v == 10, "R5 divide by 16 truncates", v, 10);
    prescaleExp = 4'd0;
  endtask

  task automatic testRestart();
    int v;
    genHigh = 20; genLow = 40; restartChannel(); waitUpdate(v);
    check(fullMeasured, "R7 full after period", fullMeasured, 1);
    @(negedge clk); enable = 1'b0;
    repeat (2) @(negedge clk);
    check(!fullMeasured, "R7 full clears on disable", fullMeasured, 0);
    genHigh = 50; genLow = 50;
    repeat (200) @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    check(!fullMeasured, "R7 no full before first period", fullMeasured, 0);
    waitUpdate(v);
    check(v == 100, "R7 fresh period after restart", v, 100);
  endtask

  task automatic testSaturate();
    int v;
    bit got = 1'b0;
    genOn = 1'b0;
    for (int i = 0; i < 3 && !got; i++) begin
      waitUpdate(v);
      if (v == SAT && fullMeasured) got = 1'b1;
    end
    check(got, "R8 saturated report", v, SAT);
    genOn = 1'b1;
  endtask

  task automatic pulseClear();
    @(negedge clk); intClearWr = 1'b1;
    @(negedge clk); intClearWr = 1'b0;
  endtask

  task automatic testIrq();
    int v;
    genHigh = 20; genLow = 40; edgeMode = 2'd1;
    limitValue = CW'(50); limitInvert = 1'b0; intEnable = 1'b1;
    restartChannel(); waitUpdate(v); waitUpdate(v);
    check(intFlag, "R9 count above limit", intFlag, 1);
    intEnable = 1'b0; pulseClear();
    check(!intFlag, "R10 clear strobe", intFlag, 0);
    limitValue = CW'(70); intEnable = 1'b1;
    waitUpdate(v); waitUpdate(v);
    check(!intFlag, "R9 count below limit no flag", intFlag, 0);
    limitInvert = 1'b1;
    waitUpdate(v); waitUpdate(v);
    check(intFlag, "R9 inverted compare", intFlag, 1);
    limitValue = '0;
    waitUpdate(v); pulseClear();
    check(!intFlag, "R10 clear with compare on", intFlag, 0);
    waitUpdate(v); waitUpdate(v);
    check(!intFlag, "R9 zero limit disables", intFlag, 0);
    intEnable = 1'b0; limitInvert = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRaw();
    testDebounce();
    testEdges();
    testBoth();
    testPrescale();
    testRestart();
    testSaturate();
    testIrq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule